// File: doc/BRIEF.md
# Three-Wire Tuner Control Receiver

This block takes tuner control words from a host over a three-wire serial bus: a frame enable, a data line and a serial clock. All three lines are brought into the system clock domain through a synchronizer chain. A data bit is taken on each falling serial-clock edge that arrives while the enable line is high. The host sends either a short 19-bit frame or a long 27-bit frame. The short frame carries the band enables and the divider setting. The long frame appends eight test bits.

Each group of fields has its own holding register, and each register loads at a fixed bit count within the frame:
- The band enables load at bit 4.
- The main (M) and swallow (S) divider words load at bit 19.
- The test fields load at bit 27.

If a frame is cut short, only the groups whose bit count has already been reached are updated. The other bits are thrown away.

A frame controller moves through three states:
- IDLE: the enable line is low.
- SHIFT: a frame is being received.
- FULL: 27 bits have been taken, and further serial clocks are ignored.

The transitions are:
- IDLE to SHIFT when the synchronized enable is seen high. This also clears the bit counter.
- SHIFT to FULL on the 27th accepted falling edge.
- SHIFT to IDLE, and FULL to IDLE, when the synchronized enable goes low.

The raw test bits are decoded into these outputs:
- charge-pump current select
- reference divide-ratio code
- tuning-amplifier disable
- charge-pump mode
- lock/test monitor selection

A sticky flag records any long frame that arrives with its mandatory-one bit at zero.

Top module: `tw_synth_rx`

## Requirements
- R1: Serial clock falling edges are counted and data is sampled only while enable is high; serial clocks while enable is low change no output.
- R2: Bits arrive band bits first. The first bit drives `band_en[3]` and the fourth drives `band_en[0]`. `band_en` takes the four band bits at the 4th accepted falling edge, before the rest of the frame arrives.
- R3: After the band bits come the ten M bits, most significant first, and then the five S bits, most significant first. `m_word` and `s_word` load at the 19th accepted falling edge.
- R4: If enable goes low before the 19th falling edge, only `band_en` may change. `m_word`, `s_word` and all test outputs keep their values.
- R5: Bits 20 to 27 are, in order, the mandatory-one bit, then CP, T2, T1, T0, RA, RB and OS, and they load at the 27th falling edge. The decodes are:
  - `cp_high` = CP.
  - `tune_off` = OS.
  - T2..T0 = 00x gives pump 0 (normal) with monitor 0 (lock).
  - T2..T0 = 01x gives pump 1 (high impedance) with monitor 0.
  - T2..T0 = 100 gives pump 1 with monitor 1 (reference).
  - T2..T0 = 101 gives pump 1 with monitor 2 (divider).
  - T2..T0 = 110 gives pump 2 (sink) with monitor 0.
  - T2..T0 = 111 gives pump 3 (source) with monitor 0.
- R6: `ref_sel` is 1 (1/512) for RA=1 and RB=1, 2 (1/1024) for RA=0 and RB=1, and 0 (1/640) whenever RB=0. Every frame that reaches the 19th falling edge forces `ref_sel` to 0 and leaves the other test outputs unchanged.
- R7: Falling edges after the 27th in the same frame are ignored.
- R8: After reset the outputs are as follows:
  - `band_en` = 0, `m_word` = 0 and `s_word` = 0.
  - `cp_high` = 1, `ref_sel` = 0 and `tune_off` = 1.
  - `pump_mode` = 1 and `mon_sel` = 0.
  - `si_err` = 0.
- R9: Each new enable-high period restarts reception at bit 1, whatever a previous frame left behind.
- R10: `si_err` is set when a 27th bit is loaded while the mandatory-one bit is 0. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Frame enable line |
| bus_data | input | 1 | Serial data line |
| bus_sclk | input | 1 | Serial clock line |
| band_en | output | 4 | Band switch enables |
| m_word | output | 10 | Main counter setting |
| s_word | output | 5 | Swallow counter setting |
| cp_high | output | 1 | Charge-pump high-current select |
| ref_sel | output | 2 | Reference divide-ratio code |
| tune_off | output | 1 | Tuning amplifier disable |
| pump_mode | output | 2 | Charge-pump mode code |
| mon_sel | output | 2 | Lock/test monitor selection |
| si_err | output | 1 | Sticky mandatory-bit error |

## Verification
A bus line that changes just after a system-clock edge reaches the controller after SYNC_STAGES edges, which is two by default. The falling-edge detector reacts in that same cycle, and the holding register loads on the next edge. Each result is therefore due three system clocks after the serial-clock fall that completes its group.

The bench drives the bus between clock edges and holds every serial-clock phase for four system clocks. It checks a group only after the phase that follows the deciding fall. For the mid-frame band check at bit 4, it samples before the fifth bit is sent.

// File: rtl/tw_rx_pkg.sv
package tw_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FULL  = 2'd2
    } rx_state_e;

    // Charge-pump mode codes
    localparam logic [1:0] PUMP_NORMAL = 2'd0;
    localparam logic [1:0] PUMP_HIZ    = 2'd1;
    localparam logic [1:0] PUMP_SINK   = 2'd2;
    localparam logic [1:0] PUMP_SOURCE = 2'd3;

    // Monitor selection codes
    localparam logic [1:0] MON_LOCK = 2'd0;
    localparam logic [1:0] MON_REF  = 2'd1;
    localparam logic [1:0] MON_DIV  = 2'd2;

    // Reference ratio codes
    localparam logic [1:0] REF_640  = 2'd0;
    localparam logic [1:0] REF_512  = 2'd1;
    localparam logic [1:0] REF_1024 = 2'd2;

    // Positions inside the stored 7-bit test word {CP,T2,T1,T0,RA,RB,OS}
    localparam int TB_OS = 0;
    localparam int TB_RB = 1;
    localparam int TB_RA = 2;
    localparam int TB_T0 = 3;
    localparam int TB_T2 = 5;
    localparam int TB_CP = 6;

    // Power-on test word: CP=1, T=010 (pump off), RA=RB=0, OS=1
    localparam logic [6:0] TEST_RESET = 7'b1_010_00_1;

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/tw_frame_fsm.sv
module tw_frame_fsm
    import tw_rx_pkg::*;
#(
    parameter int BAND_W = 4,
    parameter int M_W    = 10,
    parameter int S_W    = 5,
    parameter int TEST_W = 8,
    localparam int DIV_LAST   = BAND_W + M_W + S_W,
    localparam int FRAME_LAST = DIV_LAST + TEST_W,
    localparam int CNT_W      = $clog2(FRAME_LAST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_s,
    input  logic              sclk_s,
    input  logic              data_s,
    output logic [BAND_W-1:0] band_q,
    output logic [M_W-1:0]    m_q,
    output logic [S_W-1:0]    s_q,
    output logic [TEST_W-2:0] test_q,
    output logic              si_err_q,
    output logic              take,
    output logic [CNT_W-1:0]  bit_cnt,
    output rx_state_e         state
);

    rx_state_e                 nxt_state;
    logic [CNT_W-1:0]          nxt_cnt;
    logic [CNT_W-1:0]          cnt_inc;
    logic                      sclk_d;
    logic                      fall;
    logic [FRAME_LAST-2:0]     sh;
    logic [FRAME_LAST-1:0]     word;
    logic                      ld_band;
    logic                      ld_div;
    logic                      ld_test;

    // Falling-edge detector on the synchronized serial clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign fall    = sclk_d & ~sclk_s;
    assign take    = fall & en_s & (state == ST_SHIFT);
    assign cnt_inc = bit_cnt + 1'b1;
    assign word    = {sh, data_s};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            state   <= nxt_state;
            bit_cnt <= nxt_cnt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt_state = state;
        nxt_cnt   = bit_cnt;
        unique case (state)
            ST_IDLE: begin
                nxt_cnt = '0;
                if (en_s) nxt_state = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!en_s) begin
                    nxt_state = ST_IDLE;
                    nxt_cnt   = '0;
                end else if (take) begin
                    nxt_cnt = cnt_inc;
                    if (cnt_inc == CNT_W'(FRAME_LAST)) nxt_state = ST_FULL;
                end
            end
            ST_FULL: begin
                if (!en_s) begin
                    nxt_state = ST_IDLE;
                    nxt_cnt   = '0;
                end
            end
            default: begin
                nxt_state = ST_IDLE;
                nxt_cnt   = '0;
            end
        endcase
    end

    // Output strobes: one per field group
    always_comb begin
        ld_band = take && (cnt_inc == CNT_W'(BAND_W));
        ld_div  = take && (cnt_inc == CNT_W'(DIV_LAST));
        ld_test = take && (cnt_inc == CNT_W'(FRAME_LAST));
    end

    // Shift register and field holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh       <= '0;
            band_q   <= '0;
            m_q      <= '0;
            s_q      <= '0;
            test_q   <= TEST_RESET[TEST_W-2:0];
            si_err_q <= 1'b0;
        end else begin
            if (take) sh <= word[FRAME_LAST-2:0];
            if (ld_band) band_q <= word[BAND_W-1:0];
            if (ld_div) begin
                m_q           <= word[M_W+S_W-1:S_W];
                s_q           <= word[S_W-1:0];
                test_q[TB_RB] <= 1'b0;
            end
            if (ld_test) begin
                test_q <= word[TEST_W-2:0];
                if (!word[TEST_W-1]) si_err_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tw_test_decode.sv
module tw_test_decode
    import tw_rx_pkg::*;
(
    input  logic [6:0] tbits,
    output logic       cp_high,
    output logic       tune_off,
    output logic [1:0] ref_sel,
    output logic [1:0] pump_mode,
    output logic [1:0] mon_sel
);

    assign cp_high  = tbits[TB_CP];
    assign tune_off = tbits[TB_OS];

    always_comb begin
        unique case ({tbits[TB_RA], tbits[TB_RB]})
            2'b11:   ref_sel = REF_512;
            2'b01:   ref_sel = REF_1024;
            default: ref_sel = REF_640;
        endcase
    end

    always_comb begin
        unique case (tbits[TB_T2:TB_T0])
            3'b000, 3'b001: begin pump_mode = PUMP_NORMAL; mon_sel = MON_LOCK; end
            3'b010, 3'b011: begin pump_mode = PUMP_HIZ;    mon_sel = MON_LOCK; end
            3'b100:         begin pump_mode = PUMP_HIZ;    mon_sel = MON_REF;  end
            3'b101:         begin pump_mode = PUMP_HIZ;    mon_sel = MON_DIV;  end
            3'b110:         begin pump_mode = PUMP_SINK;   mon_sel = MON_LOCK; end
            default:        begin pump_mode = PUMP_SOURCE; mon_sel = MON_LOCK; end
        endcase
    end

endmodule

// File: rtl/tw_synth_rx.sv
module tw_synth_rx
    import tw_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BAND_W      = 4,
    parameter int M_W         = 10,
    parameter int S_W         = 5,
    parameter int TEST_W      = 8,
    localparam int FRAME_LAST = BAND_W + M_W + S_W + TEST_W,
    localparam int CNT_W      = $clog2(FRAME_LAST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_data,
    input  logic              bus_sclk,
    output logic [BAND_W-1:0] band_en,
    output logic [M_W-1:0]    m_word,
    output logic [S_W-1:0]    s_word,
    output logic              cp_high,
    output logic [1:0]        ref_sel,
    output logic              tune_off,
    output logic [1:0]        pump_mode,
    output logic [1:0]        mon_sel,
    output logic              si_err
);

    logic [2:0]        lines_s;
    logic [TEST_W-2:0] test_q;
    logic              take;
    logic [CNT_W-1:0]  bit_cnt;
    rx_state_e         state;

    tw_line_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_en, bus_sclk, bus_data}),
        .q     (lines_s)
    );

    tw_frame_fsm #(
        .BAND_W (BAND_W),
        .M_W    (M_W),
        .S_W    (S_W),
        .TEST_W (TEST_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_s     (lines_s[2]),
        .sclk_s   (lines_s[1]),
        .data_s   (lines_s[0]),
        .band_q   (band_en),
        .m_q      (m_word),
        .s_q      (s_word),
        .test_q   (test_q),
        .si_err_q (si_err),
        .take     (take),
        .bit_cnt  (bit_cnt),
        .state    (state)
    );

    tw_test_decode u_dec (
        .tbits     (test_q[6:0]),
        .cp_high   (cp_high),
        .tune_off  (tune_off),
        .ref_sel   (ref_sel),
        .pump_mode (pump_mode),
        .mon_sel   (mon_sel)
    );

endmodule

// File: rtl/tw_rx_chk.sv
module tw_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_s,
    input logic       take,
    input logic [4:0] bit_cnt,
    input logic [3:0] band_en,
    input logic [9:0] m_word,
    input logic [4:0] s_word,
    input logic [6:0] test_q,
    input logic       si_err
);

    // R1
    low_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> ($stable(band_en) && $stable(m_word) && $stable(s_word) && $stable(test_q)));

    // R2
    band_at_fourth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(band_en) |-> $past(take && bit_cnt == 5'd3));

    // R3
    div_at_nineteenth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(m_word) || !$stable(s_word)) |-> $past(take && bit_cnt == 5'd18));

    // R5
    test_at_load_points_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(test_q) |-> $past(take && (bit_cnt == 5'd26 || bit_cnt == 5'd18)));

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 5'd27);

    // R9
    idle_clears_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> bit_cnt == 5'd0);

    // R10
    si_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        si_err |=> si_err);

endmodule

bind tw_synth_rx tw_rx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_s    (lines_s[2]),
    .take    (take),
    .bit_cnt (bit_cnt),
    .band_en (band_en),
    .m_word  (m_word),
    .s_word  (s_word),
    .test_q  (test_q),
    .si_err  (si_err)
);

// File: tb/sim_tw_synth_rx.sv
module sim_tw_synth_rx;

    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_en = 1'b0;
    logic bus_data = 1'b0;
    logic bus_sclk = 1'b0;
    logic [3:0] band_en;
    logic [9:0] m_word;
    logic [4:0] s_word;
    logic cp_high, tune_off, si_err;
    logic [1:0] ref_sel, pump_mode, mon_sel;

    int total = 0;
    int failed = 0;

    always #10 clk = ~clk;

    tw_synth_rx u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_data(bus_data),
        .bus_sclk(bus_sclk), .band_en(band_en), .m_word(m_word),
        .s_word(s_word), .cp_high(cp_high), .ref_sel(ref_sel),
        .tune_off(tune_off), .pump_mode(pump_mode), .mon_sel(mon_sel),
        .si_err(si_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_test(input string tag, input logic cp, input logic [1:0] pm,
                            input logic [1:0] ms, input logic [1:0] rs, input logic to);
        chk({tag, " cp_high"}, 32'(cp_high), 32'(cp));
        chk({tag, " pump_mode"}, 32'(pump_mode), 32'(pm));
        chk({tag, " mon_sel"}, 32'(mon_sel), 32'(ms));
        chk({tag, " ref_sel"}, 32'(ref_sel), 32'(rs));
        chk({tag, " tune_off"}, 32'(tune_off), 32'(to));
    endtask

    function automatic logic [31:0] mk(input logic [3:0] b, input logic [9:0] m,
                                       input logic [4:0] s, input logic [7:0] t,
                                       input logic [4:0] extra);
        return {b, m, s, t, extra};
    endfunction

    task automatic put_bit(input logic b);
        @(negedge clk);
        bus_data = b;
        bus_sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        bus_sclk = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame_open();
        @(negedge clk);
        bus_en = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame_close();
        repeat (2) @(negedge clk);
        bus_en = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] f, input int n);
        frame_open();
        for (int i = 0; i < n; i++) put_bit(f[31-i]);
        frame_close();
    endtask

    // R8
    task automatic t_reset();
        chk("R8 band", 32'(band_en), 0);
        chk("R8 m", 32'(m_word), 0);
        chk("R8 s", 32'(s_word), 0);
        chk("R8 si_err", 32'(si_err), 0);
        chk_test("R8", 1'b1, 2'd1, 2'd0, 2'd0, 1'b1);
    endtask

    // R3 short frame, R6 ref stays 640
    task automatic t_short();
        send(mk(4'b1010, 10'h2A5, 5'h13, 8'h00, 5'h0), 19);
        chk("R2 band", 32'(band_en), 32'hA);
        chk("R3 m", 32'(m_word), 32'h2A5);
        chk("R3 s", 32'(s_word), 32'h13);
        chk_test("R6 short", 1'b1, 2'd1, 2'd0, 2'd0, 1'b1);
    endtask

    // R2 band mid-frame, R4 abort keeps divider
    task automatic t_abort_early();
        logic [31:0] f = mk(4'b0101, 10'h3FF, 5'h1F, 8'hFF, 5'h0);
        frame_open();
        for (int i = 0; i < 4; i++) put_bit(f[31-i]);
        chk("R2 band at 4th", 32'(band_en), 32'h5);
        chk("R4 m mid", 32'(m_word), 32'h2A5);
        for (int i = 4; i < 9; i++) put_bit(f[31-i]);
        frame_close();
        chk("R4 band", 32'(band_en), 32'h5);
        chk("R4 m", 32'(m_word), 32'h2A5);
        chk("R4 s", 32'(s_word), 32'h13);
        chk_test("R4", 1'b1, 2'd1, 2'd0, 2'd0, 1'b1);
    endtask

    // R5 long frames and decodes
    task automatic t_long();
        send(mk(4'b0001, 10'h155, 5'h0A, 8'b1_0_110_11_0, 5'h0), 27);
        chk("R3 m long", 32'(m_word), 32'h155);
        chk("R3 s long", 32'(s_word), 32'h0A);
        chk("R2 band long", 32'(band_en), 32'h1);
        chk_test("R5 sink", 1'b0, 2'd2, 2'd0, 2'd1, 1'b0);
        chk("R10 clean", 32'(si_err), 0);
        send(mk(4'b0001, 10'h155, 5'h0A, 8'b1_1_100_01_1, 5'h0), 27);
        chk_test("R5 ref mon", 1'b1, 2'd1, 2'd1, 2'd2, 1'b1);
        send(mk(4'b0001, 10'h155, 5'h0A, 8'b1_1_101_00_0, 5'h0), 27);
        chk_test("R5 div mon", 1'b1, 2'd1, 2'd2, 2'd0, 1'b0);
        send(mk(4'b0001, 10'h155, 5'h0A, 8'b1_0_111_11_0, 5'h0), 27);
        chk_test("R5 source", 1'b0, 2'd3, 2'd0, 2'd1, 1'b0);
    endtask

    // R6 a short frame forces 1/640, other test fields kept
    task automatic t_ref_force();
        send(mk(4'b1000, 10'h001, 5'h01, 8'h00, 5'h0), 19);
        chk_test("R6 force", 1'b0, 2'd3, 2'd0, 2'd0, 1'b0);
        chk("R6 m", 32'(m_word), 32'h001);
    endtask

    // R4/R6 abort between 19 and 27
    task automatic t_abort_late();
        send(mk(4'b0110, 10'h0F0, 5'h05, 8'b1_1_000_11_1, 5'h0), 22);
        chk("R3 m late abort", 32'(m_word), 32'h0F0);
        chk("R3 s late abort", 32'(s_word), 32'h05);
        chk("R2 band late abort", 32'(band_en), 32'h6);
        chk_test("R4 test kept", 1'b0, 2'd3, 2'd0, 2'd0, 1'b0);
    endtask

    // R7 extra clocks ignored
    task automatic t_extra();
        send(mk(4'b1100, 10'h00F, 5'h1E, 8'b1_1_001_11_1, 5'b10101), 32);
        chk("R7 band", 32'(band_en), 32'hC);
        chk("R7 m", 32'(m_word), 32'h00F);
        chk("R7 s", 32'(s_word), 32'h1E);
        chk_test("R7", 1'b1, 2'd0, 2'd0, 2'd1, 1'b1);
    endtask

    // R9 restart at bit 1
    task automatic t_restart();
        send(mk(4'b1111, 10'h3FF, 5'h1F, 8'hFF, 5'h0), 10);
        chk("R9 band partial", 32'(band_en), 32'hF);
        send(mk(4'b0011, 10'h123, 5'h07, 8'h00, 5'h0), 19);
        chk("R9 band", 32'(band_en), 32'h3);
        chk("R9 m", 32'(m_word), 32'h123);
        chk("R9 s", 32'(s_word), 32'h07);
    endtask

    // R1 clocks with enable low
    task automatic t_enable_low();
        for (int i = 0; i < 20; i++) put_bit(1'b1);
        repeat (6) @(negedge clk);
        chk("R1 band", 32'(band_en), 32'h3);
        chk("R1 m", 32'(m_word), 32'h123);
        chk("R1 s", 32'(s_word), 32'h07);
    endtask

    // R10 sticky error
    task automatic t_si();
        send(mk(4'b0010, 10'h010, 5'h02, 8'b0_1_000_00_1, 5'h0), 27);
        chk("R10 set", 32'(si_err), 1);
        send(mk(4'b0010, 10'h010, 5'h02, 8'b1_1_000_00_1, 5'h0), 27);
        chk("R10 sticky", 32'(si_err), 1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_short();
        t_abort_early();
        t_long();
        t_ref_force();
        t_abort_late();
        t_extra();
        t_restart();
        t_enable_low();
        t_si();
        finish_run();
    end

endmodule